// File: doc/BRIEF.md
# Pin Port with Edge and Level Interrupts

This block is a general-purpose I/O port with 32 pins by default. A simple memory-mapped bus reads and writes it. The port keeps an output value and an output-enable for each pin. It samples the external pins through a two-stage synchronizer and returns the sampled state to software. The output value can be changed three ways: by a whole-word write, or by a write that only sets chosen bits, or by a write that only clears chosen bits. Two pull-control words are stored and read back, and the port does nothing else with them.

Each pin can raise an interrupt. Three configuration bits per pin choose the trigger:
- a sense bit picks edge or level;
- a polarity bit picks rising or falling in edge mode, and high or low in level mode;
- a dual-edge bit makes an edge-mode pin fire on any change.

A pin marks a pending event only while its enable bit is set. Pending bits stay set until software writes a one to them through the acknowledge word. A mask word can hide pending bits from the single port interrupt line without clearing them.

The bus has no wait states. A write takes effect at the clock edge where select and write are both high. Read data is valid in the same cycle as the read request.

Top module: `gpio_irq_port`

## Requirements
- R1: Stored words read back the last value written, at these byte offsets: output value 0x00, direction 0x08, pull-enable 0x18, pull-select 0x1C, interrupt enable 0x20, interrupt mask 0x2C, sense 0x34, dual-edge 0x38, polarity 0x3C.
- R2: `pin_out` equals the output-value word. `pin_oe` equals the direction word, where 1 drives the pin and 0 leaves it as an input.
- R3: A write to offset 0x10 sets every output bit written as 1. A write to offset 0x14 clears every output bit written as 1. Output bits written as 0 keep their value.
- R4: Offset 0x04 returns the synchronized pins. A change at `pin_in` shows there after two rising clock edges, and not after one.
- R5: A pin with sense bit 0 and dual-edge bit 0 latches a pending bit (offset 0x24) on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The bit is set on the third clock edge after the pin changes.
- R6: A pin with sense bit 0 and dual-edge bit 1 latches on either edge, whatever its polarity bit says.
- R7: A pin with sense bit 1 latches while the synchronized level is high (polarity 0) or low (polarity 1). The dual-edge bit has no effect in this mode. If the level is still active after an acknowledge, the pending bit sets again on the next clock edge.
- R8: A pin whose enable bit is 0 never sets its pending bit.
- R9: Writing 1s to offset 0x30 clears those pending bits. Bits written as 0 are untouched. When an acknowledge and a new event hit the same bit on the same clock edge, the acknowledge wins.
- R10: `irq` is high exactly when some pending bit has a mask bit of 0. Mask bits never change the pending bits themselves.
- R11: Reads of offsets 0x0C, 0x28, 0x40 and of the write-only offsets 0x10, 0x14, 0x30 return 0. Writes to the unmapped offsets change no stored word.
- R12: After reset, every stored word and every pending bit is 0, and `pin_out`, `pin_oe` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pin_in | input | 32 | External pin levels |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined port interrupt |

## Verification
A wrong trigger decode or a wrong stored configuration bit appears at offset 0x24 within four cycles of the pin change that should, or should not, have fired it. The bench therefore sweeps every trigger mode across every pin at once and reads the full pending word after each transition. A wrong acknowledge priority shows up in the very cycle after the write, because a level pin that is still active must read 0 there and 1 one cycle later. A mask or enable fault shows on `irq` or on the pending word as soon as the combined value is sampled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_DOUT   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_DIN    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_DIR    = 8'h08;
  localparam logic [OFS_W-1:0] OFS_SET    = 8'h10;
  localparam logic [OFS_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [OFS_W-1:0] OFS_PEN    = 8'h18;
  localparam logic [OFS_W-1:0] OFS_PSEL   = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_IEN    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_IPEND  = 8'h24;
  localparam logic [OFS_W-1:0] OFS_IMASK  = 8'h2C;
  localparam logic [OFS_W-1:0] OFS_IACK   = 8'h30;
  localparam logic [OFS_W-1:0] OFS_SENSE  = 8'h34;
  localparam logic [OFS_W-1:0] OFS_DUAL   = 8'h38;
  localparam logic [OFS_W-1:0] OFS_POL    = 8'h3C;

  // Trigger decision for one pin.
  // sense=1 selects level mode; pol picks falling/low when 1.
  function automatic logic trig_hit(input logic sense, input logic pol,
                                    input logic dual, input logic cur,
                                    input logic prev);
    logic hit;
    if (sense)
      hit = cur ^ pol;
    else if (dual)
      hit = cur ^ prev;
    else if (pol)
      hit = prev & ~cur;
    else
      hit = cur & ~prev;
    return hit;
  endfunction

  // Next pending bit: an acknowledge overrides a new event.
  function automatic logic pend_next(input logic pend, input logic ack,
                                     input logic en, input logic hit);
    return ~ack & (pend | (en & hit));
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] cfg_sense,
  input  logic [W-1:0] cfg_pol,
  input  logic [W-1:0] cfg_dual,
  input  logic [W-1:0] cfg_en,
  input  logic [W-1:0] cfg_mask,
  input  logic [W-1:0] ack_vec,
  output logic [W-1:0] hit_vec,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl_now;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit_vec[i] = trig_hit(cfg_sense[i], cfg_pol[i], cfg_dual[i],
                                 lvl_now[i], lvl_prev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= pend_next(pend[i], ack_vec[i], cfg_en[i], hit_vec[i]);
    end
  end

  assign irq = |(pend & ~cfg_mask);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     lvl_now,
  input  logic [W-1:0]     pend,
  output logic [W-1:0]     r_dout,
  output logic [W-1:0]     r_dir,
  output logic [W-1:0]     r_en,
  output logic [W-1:0]     r_mask,
  output logic [W-1:0]     r_sense,
  output logic [W-1:0]     r_dual,
  output logic [W-1:0]     r_pol,
  output logic [W-1:0]     ack_vec
);
  logic         wr_en;
  logic         rd_en;
  logic [W-1:0] r_pen;
  logic [W-1:0] r_psel;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign ack_vec = (wr_en && bus_addr == OFS_IACK) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dout  <= '0;
      r_dir   <= '0;
      r_pen   <= '0;
      r_psel  <= '0;
      r_en    <= '0;
      r_mask  <= '0;
      r_sense <= '0;
      r_dual  <= '0;
      r_pol   <= '0;
    end else if (wr_en) begin
      unique case (bus_addr)
        OFS_DOUT:  r_dout  <= bus_wdata;
        OFS_SET:   r_dout  <= r_dout | bus_wdata;
        OFS_CLR:   r_dout  <= r_dout & ~bus_wdata;
        OFS_DIR:   r_dir   <= bus_wdata;
        OFS_PEN:   r_pen   <= bus_wdata;
        OFS_PSEL:  r_psel  <= bus_wdata;
        OFS_IEN:   r_en    <= bus_wdata;
        OFS_IMASK: r_mask  <= bus_wdata;
        OFS_SENSE: r_sense <= bus_wdata;
        OFS_DUAL:  r_dual  <= bus_wdata;
        OFS_POL:   r_pol   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_DOUT:  bus_rdata = r_dout;
        OFS_DIN:   bus_rdata = lvl_now;
        OFS_DIR:   bus_rdata = r_dir;
        OFS_PEN:   bus_rdata = r_pen;
        OFS_PSEL:  bus_rdata = r_psel;
        OFS_IEN:   bus_rdata = r_en;
        OFS_IPEND: bus_rdata = pend;
        OFS_IMASK: bus_rdata = r_mask;
        OFS_SENSE: bus_rdata = r_sense;
        OFS_DUAL:  bus_rdata = r_dual;
        OFS_POL:   bus_rdata = r_pol;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  // Internal events brought out by name for the checker.
  logic [NPINS-1:0] lvl_now;
  logic [NPINS-1:0] hit_vec;
  logic [NPINS-1:0] ack_vec;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] r_en;
  logic [NPINS-1:0] r_mask;
  logic [NPINS-1:0] r_sense;
  logic [NPINS-1:0] r_dual;
  logic [NPINS-1:0] r_pol;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .d_sync  (lvl_now)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lvl_now   (lvl_now),
    .pend      (pend),
    .r_dout    (pin_out),
    .r_dir     (pin_oe),
    .r_en      (r_en),
    .r_mask    (r_mask),
    .r_sense   (r_sense),
    .r_dual    (r_dual),
    .r_pol     (r_pol),
    .ack_vec   (ack_vec)
  );

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_now   (lvl_now),
    .cfg_sense (r_sense),
    .cfg_pol   (r_pol),
    .cfg_dual  (r_dual),
    .cfg_en    (r_en),
    .cfg_mask  (r_mask),
    .ack_vec   (ack_vec),
    .hit_vec   (hit_vec),
    .pend      (pend),
    .irq       (irq)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [OFS_W-1:0] bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] ack_vec,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] r_en,
  input logic [NPINS-1:0] r_mask
);
  logic set_wr;
  logic any_wr;
  assign set_wr = bus_sel & bus_wr & (bus_addr == OFS_SET);
  assign any_wr = bus_sel & bus_wr;

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(pin_oe));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(r_en)) == '0));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((pend & $past(ack_vec)) == '0));

  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(ack_vec) & ~pend) == '0));

  assert_all_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&r_mask) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .ack_vec   (ack_vec),
  .pend      (pend),
  .r_en      (r_en),
  .r_mask    (r_mask)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, commit at the rising edge, return at the next falling edge.
  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Combinational read inside the low phase; consumes no clock edge.
  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic int mode_of(input int i);
    return i % 5;
  endfunction

  function automatic logic [N-1:0] cfg_word(input int which);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      int m = mode_of(i);
      case (which)
        0: v[i] = (m >= 3);
        1: v[i] = (m == 1) || (m == 2) || (m == 4);
        default: v[i] = (m == 2) || (m == 4);
      endcase
    end
    return v;
  endfunction

  // Pending pattern after an acknowledge, the pins held at a, then moved to b.
  function automatic logic [N-1:0] expect_pend(input logic [N-1:0] a,
                                               input logic [N-1:0] b);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      case (mode_of(i))
        0: v[i] = !a[i] && b[i];
        1: v[i] = a[i] && !b[i];
        2: v[i] = a[i] != b[i];
        3: v[i] = a[i] || b[i];
        default: v[i] = !a[i] || !b[i];
      endcase
    end
    return v;
  endfunction

  logic [7:0] stored_ofs [9] = '{8'h00, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h2C, 8'h34, 8'h38, 8'h3C};
  logic [N-1:0] vecs [7] = '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5,
                             32'h5A5A_5A5A, 32'h1234_5678, 32'h0};

  task automatic sweep(input logic [N-1:0] en, input string req);
    logic [N-1:0] got;
    logic [N-1:0] expv;
    for (int k = 1; k < 7; k++) begin
      wr(8'h30, '1);
      pin_in = vecs[k];
      repeat (4) @(negedge clk);
      rd(8'h24, got);
      expv = expect_pend(vecs[k-1], vecs[k]) & en;
      check(got == expv, req, got, expv);
      check(irq == |expv, "R10 irq", {31'b0, irq}, {31'b0, |expv});
    end
  endtask

  initial begin
    logic [N-1:0] got;
    logic [N-1:0] expv;
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int j = 0; j < 9; j++) begin
      rd(stored_ofs[j], got);
      check(got == '0, "R12 stored word", got, '0);
    end
    rd(8'h24, got);
    check(got == '0, "R12 pending", got, '0);
    check({pin_out, pin_oe} == '0 && !irq, "R12 outputs", pin_out | pin_oe, '0);

    // R1 readback
    for (int j = 0; j < 9; j++) begin
      pat = {4{stored_ofs[j]}} ^ 32'hC3A5_0F96;
      wr(stored_ofs[j], pat);
      rd(stored_ofs[j], got);
      check(got == pat, "R1 readback", got, pat);
    end
    // R2 pins follow stored words
    check(pin_out == ({4{8'h00}} ^ 32'hC3A5_0F96), "R2 pin_out", pin_out, {4{8'h00}} ^ 32'hC3A5_0F96);
    check(pin_oe == ({4{8'h08}} ^ 32'hC3A5_0F96), "R2 pin_oe", pin_oe, {4{8'h08}} ^ 32'hC3A5_0F96);

    // R11 unmapped writes ignored, write-only and unmapped reads zero
    wr(8'h0C, '1); wr(8'h28, '1); wr(8'h40, '1);
    for (int j = 0; j < 9; j++) begin
      pat = {4{stored_ofs[j]}} ^ 32'hC3A5_0F96;
      rd(stored_ofs[j], got);
      check(got == pat, "R11 unchanged", got, pat);
    end
    rd(8'h0C, got); check(got == '0, "R11 read 0C", got, '0);
    rd(8'h28, got); check(got == '0, "R11 read 28", got, '0);
    rd(8'h40, got); check(got == '0, "R11 read 40", got, '0);
    rd(8'h10, got); check(got == '0, "R11 read 10", got, '0);
    rd(8'h14, got); check(got == '0, "R11 read 14", got, '0);
    rd(8'h30, got); check(got == '0, "R11 read 30", got, '0);

    // R3 set and clear
    wr(8'h00, 32'hF0F0_00FF);
    wr(8'h10, 32'h0F00_0F01);
    expv = 32'hF0F0_00FF | 32'h0F00_0F01;
    check(pin_out == expv, "R3 set", pin_out, expv);
    wr(8'h14, 32'h8001_0F10);
    expv = expv & ~32'h8001_0F10;
    rd(8'h00, got);
    check(got == expv, "R3 clear", got, expv);
    wr(8'h10, '0); wr(8'h14, '0);
    check(pin_out == expv, "R3 zero write keeps", pin_out, expv);

    // Interrupt setup: all disabled, unmasked, cleared
    wr(8'h20, '0); wr(8'h2C, '0); wr(8'h30, '1);

    // R4 synchronizer latency
    pin_in = 32'h9C3E_1B27;
    @(negedge clk);
    rd(8'h04, got);
    check(got == '0, "R4 one edge", got, '0);
    @(negedge clk);
    rd(8'h04, got);
    check(got == 32'h9C3E_1B27, "R4 two edges", got, 32'h9C3E_1B27);
    pin_in = '0;
    repeat (4) @(negedge clk);
    // R8 with everything disabled nothing pends
    rd(8'h24, got);
    check(got == '0, "R8 all disabled", got, '0);

    // Mode configuration across pins: i%5 -> rise, fall, dual, high, low
    wr(8'h34, cfg_word(0));
    wr(8'h3C, cfg_word(1));
    wr(8'h38, cfg_word(2));
    wr(8'h20, '1);
    sweep('1, "R5 R6 R7 pending");
    wr(8'h20, 32'h0F0F_0F0F);
    sweep(32'h0F0F_0F0F, "R8 partial enable");
    wr(8'h20, '1);

    // R9 acknowledge wins; R7 level re-sets next edge. Pins now 0: low-level pins active.
    wr(8'h30, '1);
    rd(8'h24, got);
    check(got == '0, "R9 ack wins", got, '0);
    @(negedge clk);
    rd(8'h24, got);
    expv = expect_pend('0, '0);
    check(got == expv, "R7 level re-set", got, expv);
    // R9 zero bits untouched
    pat = 32'h0000_FFFF;
    wr(8'h30, pat & 32'h0);
    rd(8'h24, got);
    check(got == expv, "R9 zero ack", got, expv);

    // R10 mask sweep over the pending pattern
    for (int s = 0; s < 8; s++) begin
      pat = ~(32'h1 << (s * 4)) & ((s[0]) ? 32'hFFFF_FFFF : 32'hEEEE_EEEE);
      wr(8'h2C, pat);
      check(irq == |(expv & ~pat), "R10 mask", {31'b0, irq}, {31'b0, |(expv & ~pat)});
      rd(8'h24, got);
      check(got == expv, "R10 pend untouched", got, expv);
    end
    wr(8'h2C, '1);
    check(!irq, "R10 all masked", {31'b0, irq}, '0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule